// File: doc/BRIEF.md
# Serial register-bus front end with short and long command forms

This block is the serial slave port of a radio MAC controller. A host talks to it over a four-wire SPI link in mode 0: clock idle low, MOSI sampled on rising SCK, MISO changed on falling SCK, most significant bit first. Each transaction opens with a command. The first bit on the wire picks the command form. A one-byte short command reaches a 64-entry control register space. A two-byte long command reaches a 1024-entry space that holds the long registers and both frame FIFOs.

The block turns the serial traffic into single-cycle strobes on a plain internal bus. That bus carries an address, write data, a write strobe, a read strobe, a space flag and read data, and the register file sits behind it. Further data bytes clocked in after a command go to successive addresses, so one command can stream a whole frame into the transmit FIFO. Raising chip select ends the transaction at any point. All SPI inputs are synchronized into the system clock domain, which must run at least four times faster than SCK.

Top module: `spi_regbus_slave`

## Requirements
- R1: After reset `bus_we`, `bus_re` and `spi_miso` are all 0.
- R2: A short command has bit 7 equal to 0, the address in bits 6:1 and the write flag in bit 0 (1 means write). When bit 0 is 1, the next byte causes one `bus_we` pulse with `bus_long`=0, `bus_addr` equal to the 6-bit address zero-extended, and `bus_wdata` equal to that byte.
- R3: A short command with bit 0 equal to 0 issues `bus_re` at its address with `bus_long`=0. The byte that follows the command returns the value `bus_rdata` held in that read cycle on MISO, MSB first.
- R4: A long command is 16 bits with bit 15 equal to 1, the address in bits 14:5 and the write flag in bit 4 (1 means write). With the flag set, the third byte causes one `bus_we` pulse with `bus_long`=1, that address and that data.
- R5: A long command with bit 4 equal to 0 issues `bus_re` with `bus_long`=1 at its address. The following byte returns the read data on MISO, MSB first.
- R6: In a write transaction every further data byte produces a write to the next address. Long addresses wrap modulo 1024 and short addresses wrap modulo 64.
- R7: In a read transaction every completed data byte launches a read of the next address, with the same wrap rules as R6. Successive MISO bytes therefore return successive locations.
- R8: Raising chip select in the middle of a byte discards that partial byte without any bus strobe, and the next transaction is decoded from a fresh command.
- R9: `bus_we` and `bus_re` are single-cycle pulses and are never high together.
- R10: MISO is 0 during command bytes and during the data bytes of write transactions.
- R11: A bus strobe rises exactly 3 system clock cycles after the SCK rising edge that completes the byte causing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| bus_addr | output | 10 | Internal bus address, valid with a strobe |
| bus_wdata | output | 8 | Internal bus write data, valid with `bus_we` |
| bus_we | output | 1 | Write strobe, one cycle |
| bus_re | output | 1 | Read strobe, one cycle |
| bus_long | output | 1 | 1 selects the long space, 0 the short space |
| bus_rdata | input | 8 | Read data, valid in the cycle `bus_re` is high |

## Verification
Two synchronizer stages, an edge flop and the output register put every bus strobe exactly three system cycles after the SCK rise that finishes its byte. The bench timestamps each strobe with a monitor at the falling system clock edge and compares it against the cycle in which it raised SCK. Read data must reach the shift register before the next falling SCK edge, which comes at least eight cycles after that rise. The bench samples MISO at the instant it raises SCK, so any late load shows up as a wrong bit. Bus write and read events are compared against expectations only after the transaction closes and chip select has been high for a full SCK period.

// File: rtl/spi_regbus_pkg.sv
package spi_regbus_pkg;

    parameter int unsigned SPI_DW      = 8;   // bits per serial byte
    parameter int unsigned SPI_SHORT_AW = 6;  // short register space address width
    parameter int unsigned SPI_LONG_AW = 10;  // long space address width
    parameter int unsigned SPI_SYNC    = 2;   // synchronizer depth

    typedef enum logic [1:0] {
        ST_CMD,    // waiting for the first command byte
        ST_LADDR,  // waiting for the second byte of a long command
        ST_DATA    // data bytes of a read or write
    } dec_st_e;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int unsigned STAGES = spi_regbus_pkg::SPI_SYNC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic cs_act_o,
    output logic mosi_o
);

    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] cs_n;
        logic [STAGES-1:0] mosi;
        logic              sck_last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.sck      = {sync_q.sck[STAGES-2:0], sck_i};
        sync_d.cs_n     = {sync_q.cs_n[STAGES-2:0], cs_n_i};
        sync_d.mosi     = {sync_q.mosi[STAGES-2:0], mosi_i};
        sync_d.sck_last = sync_q.sck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q          <= '0;
            sync_q.cs_n     <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sck_rise_o = sync_q.sck[STAGES-1] & ~sync_q.sck_last;
    assign sck_fall_o = ~sync_q.sck[STAGES-1] & sync_q.sck_last;
    assign cs_act_o   = ~sync_q.cs_n[STAGES-1];
    assign mosi_o     = sync_q.mosi[STAGES-1];

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int unsigned DW = spi_regbus_pkg::SPI_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_rise_i,
    input  logic          sck_fall_i,
    input  logic          cs_act_i,
    input  logic          mosi_i,
    input  logic [DW-1:0] tx_byte_i,
    output logic          byte_done_o,
    output logic [DW-1:0] rx_byte_o,
    output logic          miso_o
);

    localparam int unsigned CW = $clog2(DW);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    typedef struct packed {
        logic [DW-2:0] sh;   // bits received so far in this byte
        logic [CW-1:0] cnt;  // bit index within the byte
        logic [DW-1:0] tx;   // outgoing byte, MSB on MISO
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (!cs_act_i) begin
            shf_d = '0;
        end else begin
            if (sck_rise_i) begin
                shf_d.sh  = {shf_q.sh[DW-3:0], mosi_i};
                shf_d.cnt = (shf_q.cnt == LAST_BIT) ? '0 : shf_q.cnt + 1'b1;
            end
            if (sck_fall_i) begin
                // first falling edge after a byte boundary presents a new byte
                if (shf_q.cnt == '0) begin
                    shf_d.tx = tx_byte_i;
                end else begin
                    shf_d.tx = {shf_q.tx[DW-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign byte_done_o = cs_act_i & sck_rise_i & (shf_q.cnt == LAST_BIT);
    assign rx_byte_o   = {shf_q.sh, mosi_i};
    assign miso_o      = shf_q.tx[DW-1];

endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
    import spi_regbus_pkg::*;
#(
    parameter int unsigned DW       = SPI_DW,
    parameter int unsigned SHORT_AW = SPI_SHORT_AW,
    parameter int unsigned LONG_AW  = SPI_LONG_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_act_i,
    input  logic               byte_done_i,
    input  logic [DW-1:0]      rx_byte_i,
    input  logic [DW-1:0]      bus_rdata_i,
    output logic [LONG_AW-1:0] bus_addr_o,
    output logic [DW-1:0]      bus_wdata_o,
    output logic               bus_we_o,
    output logic               bus_re_o,
    output logic               bus_long_o,
    output logic [DW-1:0]      tx_byte_o
);

    // long command: first byte carries the form bit and the upper address bits,
    // second byte carries the lower address bits and then the write flag
    localparam int unsigned HI_W   = DW - 1;
    localparam int unsigned LO_W   = LONG_AW - HI_W;
    localparam int unsigned LWR    = DW - 1 - LO_W;
    localparam int unsigned PAD_W  = LONG_AW - SHORT_AW;

    typedef struct packed {
        dec_st_e            st;
        logic               wr;
        logic               lng;
        logic [HI_W-1:0]    cmd_hi;
        logic [LONG_AW-1:0] ptr;
        logic [LONG_AW-1:0] addr;
        logic [DW-1:0]      wdata;
        logic               we;
        logic               re;
        logic [DW-1:0]      hold;
    } dec_t;

    dec_t dec_d, dec_q;

    function automatic logic [LONG_AW-1:0] step_addr(input logic [LONG_AW-1:0] p,
                                                      input logic lng);
        if (lng) begin
            return p + 1'b1;
        end
        return {{PAD_W{1'b0}}, p[SHORT_AW-1:0] + 1'b1};
    endfunction

    always_comb begin
        logic [LONG_AW-1:0] a;
        dec_d    = dec_q;
        dec_d.we = 1'b0;
        dec_d.re = 1'b0;
        a        = '0;
        if (dec_q.re) begin
            dec_d.hold = bus_rdata_i;
        end
        if (!cs_act_i) begin
            dec_d.st   = ST_CMD;
            dec_d.hold = '0;
        end else if (byte_done_i) begin
            unique case (dec_q.st)
                ST_CMD: begin
                    if (rx_byte_i[DW-1]) begin
                        dec_d.lng    = 1'b1;
                        dec_d.cmd_hi = rx_byte_i[HI_W-1:0];
                        dec_d.st     = ST_LADDR;
                    end else begin
                        a         = {{PAD_W{1'b0}}, rx_byte_i[SHORT_AW:1]};
                        dec_d.lng = 1'b0;
                        dec_d.wr  = rx_byte_i[0];
                        dec_d.st  = ST_DATA;
                        dec_d.ptr = a;
                        if (!rx_byte_i[0]) begin
                            dec_d.addr = a;
                            dec_d.re   = 1'b1;
                            dec_d.ptr  = step_addr(a, 1'b0);
                        end
                    end
                end
                ST_LADDR: begin
                    a         = {dec_q.cmd_hi, rx_byte_i[DW-1 -: LO_W]};
                    dec_d.wr  = rx_byte_i[LWR];
                    dec_d.st  = ST_DATA;
                    dec_d.ptr = a;
                    if (!rx_byte_i[LWR]) begin
                        dec_d.addr = a;
                        dec_d.re   = 1'b1;
                        dec_d.ptr  = step_addr(a, 1'b1);
                    end
                end
                ST_DATA: begin
                    dec_d.addr = dec_q.ptr;
                    dec_d.ptr  = step_addr(dec_q.ptr, dec_q.lng);
                    if (dec_q.wr) begin
                        dec_d.wdata = rx_byte_i;
                        dec_d.we    = 1'b1;
                    end else begin
                        dec_d.re = 1'b1;   // fetch the byte after this one
                    end
                end
                default: dec_d.st = ST_CMD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q    <= '0;
            dec_q.st <= ST_CMD;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign bus_addr_o  = dec_q.addr;
    assign bus_wdata_o = dec_q.wdata;
    assign bus_we_o    = dec_q.we;
    assign bus_re_o    = dec_q.re;
    assign bus_long_o  = dec_q.lng;
    assign tx_byte_o   = dec_q.hold;

endmodule

// File: rtl/spi_regbus_slave.sv
module spi_regbus_slave
    import spi_regbus_pkg::*;
#(
    parameter int unsigned DW          = SPI_DW,
    parameter int unsigned SHORT_AW    = SPI_SHORT_AW,
    parameter int unsigned LONG_AW     = SPI_LONG_AW,
    parameter int unsigned SYNC_STAGES = SPI_SYNC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sck,
    input  logic               spi_cs_n,
    input  logic               spi_mosi,
    output logic               spi_miso,
    output logic [LONG_AW-1:0] bus_addr,
    output logic [DW-1:0]      bus_wdata,
    output logic               bus_we,
    output logic               bus_re,
    output logic               bus_long,
    input  logic [DW-1:0]      bus_rdata
);

    logic          sck_rise, sck_fall, cs_act, mosi_s;
    logic          byte_done;
    logic [DW-1:0] rx_byte, tx_byte;

    spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (spi_sck),
        .cs_n_i     (spi_cs_n),
        .mosi_i     (spi_mosi),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall),
        .cs_act_o   (cs_act),
        .mosi_o     (mosi_s)
    );

    spi_byte_shifter #(.DW(DW)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_rise_i  (sck_rise),
        .sck_fall_i  (sck_fall),
        .cs_act_i    (cs_act),
        .mosi_i      (mosi_s),
        .tx_byte_i   (tx_byte),
        .byte_done_o (byte_done),
        .rx_byte_o   (rx_byte),
        .miso_o      (spi_miso)
    );

    spi_cmd_decode #(.DW(DW), .SHORT_AW(SHORT_AW), .LONG_AW(LONG_AW)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_act_i    (cs_act),
        .byte_done_i (byte_done),
        .rx_byte_i   (rx_byte),
        .bus_rdata_i (bus_rdata),
        .bus_addr_o  (bus_addr),
        .bus_wdata_o (bus_wdata),
        .bus_we_o    (bus_we),
        .bus_re_o    (bus_re),
        .bus_long_o  (bus_long),
        .tx_byte_o   (tx_byte)
    );

endmodule

// File: rtl/spi_regbus_checks.sv
module spi_regbus_checks #(
    parameter int unsigned SHORT_AW = 6,
    parameter int unsigned LONG_AW  = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               spi_cs_n,
    input logic               bus_we,
    input logic               bus_re,
    input logic               bus_long,
    input logic [LONG_AW-1:0] bus_addr
);

    logic               seen_q;
    logic [LONG_AW-1:0] last_q;
    logic [LONG_AW-1:0] next_exp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (bus_we || bus_re) begin
            seen_q <= 1'b1;
            last_q <= bus_addr;
        end else if (spi_cs_n) begin
            seen_q <= 1'b0;
        end
    end

    assign next_exp = bus_long ? last_q + 1'b1
                               : {{(LONG_AW-SHORT_AW){1'b0}}, last_q[SHORT_AW-1:0] + 1'b1};

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re)) else $error("write and read strobe together"); // R9

    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> !bus_we) else $error("write strobe longer than one cycle"); // R9

    AST_RE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> !bus_re) else $error("read strobe longer than one cycle"); // R9

    AST_SHORT_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_we || bus_re) && !bus_long) |-> (bus_addr[LONG_AW-1:SHORT_AW] == '0))
        else $error("short access outside short space"); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_we || bus_re) && seen_q) |-> (bus_addr == next_exp))
        else $error("burst address did not step by one"); // R6

endmodule

bind spi_regbus_slave spi_regbus_checks #(
    .SHORT_AW (SHORT_AW),
    .LONG_AW  (LONG_AW)
) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_long (bus_long),
    .bus_addr (bus_addr)
);

// File: tb/test_spi_regbus_slave.sv
`timescale 1ns/1ps
module test_spi_regbus_slave;

    localparam int HALF     = 8;       // SCK half period in system cycles
    localparam int WD_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic [9:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_we, bus_re, bus_long;
    logic [7:0] bus_rdata;

    always #2.5 clk = ~clk;

    spi_regbus_slave i_spi_regbus_slave (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_long(bus_long), .bus_rdata(bus_rdata)
    );

    int cyc = 0;
    int nchk = 0;
    int nerr = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // register space model behind the bus
    logic [7:0] smem [64];
    logic [7:0] lmem [1024];
    function automatic logic [7:0] init_s(input int a); return 8'((a * 3 + 8'h40) & 8'hFF); endfunction
    function automatic logic [7:0] init_l(input int a); return 8'((a * 13 + 5) & 8'hFF); endfunction
    assign bus_rdata = bus_long ? lmem[bus_addr] : smem[bus_addr[5:0]];

    // bus event logs
    int nw = 0, nr = 0, overlap = 0;
    int w_addr [256]; int w_data [256]; int w_long [256]; int w_cyc [256];
    int r_addr [256]; int r_long [256]; int r_cyc [256];

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) smem[i] = init_s(i);
            for (int i = 0; i < 1024; i++) lmem[i] = init_l(i);
        end else begin
            if (bus_we && bus_re) overlap++;
            if (bus_we) begin
                w_addr[nw % 256] = int'(bus_addr); w_data[nw % 256] = int'(bus_wdata);
                w_long[nw % 256] = int'(bus_long); w_cyc[nw % 256] = cyc;
                if (bus_long) lmem[bus_addr] = bus_wdata; else smem[bus_addr[5:0]] = bus_wdata;
                nw++;
            end
            if (bus_re) begin
                r_addr[nr % 256] = int'(bus_addr); r_long[nr % 256] = int'(bus_long);
                r_cyc[nr % 256] = cyc;
                nr++;
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    always @(posedge clk) begin
        if (cyc == WD_LIMIT) begin
            nchk++; nerr++;
            $display("FAIL R1 watchdog: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // SPI master
    logic [7:0] txb [8];
    logic [7:0] rxb [8];
    int         rise_cyc [8];

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_run(input int nbits);
        for (int i = 0; i < 8; i++) rxb[i] = 8'h00;
        @(negedge clk);
        spi_cs_n = 1'b0;
        wait_n(HALF);
        for (int b = 0; b < nbits; b++) begin
            spi_mosi = txb[b / 8][7 - (b % 8)];
            wait_n(HALF);
            spi_sck = 1'b1;
            rxb[b / 8][7 - (b % 8)] = spi_miso;
            rise_cyc[b / 8] = cyc;
            wait_n(HALF);
            spi_sck = 1'b0;
        end
        wait_n(HALF);
        spi_cs_n = 1'b1;
        wait_n(2 * HALF);
    endtask

    function automatic logic [7:0] scmd(input int a, input bit wr);
        return {1'b0, 6'(a), wr};
    endfunction
    function automatic logic [15:0] lcmd(input int a, input bit wr);
        return 16'h8000 | (16'(a & 10'h3FF) << 5) | (wr ? 16'h0010 : 16'h0000);
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "bus_we after reset", int'(bus_we), 0);
        chk("R1", "bus_re after reset", int'(bus_re), 0);
        chk("R1", "miso after reset", int'(spi_miso), 0);
    endtask

    task automatic t_short_write();
        int b = nw;
        txb[0] = scmd(6'h15, 1'b1); txb[1] = 8'hA7;
        spi_run(16);
        chk("R2", "short write count", nw - b, 1);
        chk("R2", "short write addr", w_addr[b], 'h15);
        chk("R2", "short write space", w_long[b], 0);
        chk("R2", "short write data", w_data[b], 'hA7);
        chk("R11", "write strobe latency", w_cyc[b] - rise_cyc[1], 3);
        chk("R10", "miso cmd byte", int'(rxb[0]), 0);
        chk("R10", "miso write data byte", int'(rxb[1]), 0);
    endtask

    task automatic t_short_read();
        int b = nr;
        txb[0] = scmd(6'h15, 1'b0); txb[1] = 8'h00;
        spi_run(16);
        chk("R3", "short read data", int'(rxb[1]), 'hA7);
        chk("R3", "short read addr", r_addr[b], 'h15);
        chk("R3", "short read space", r_long[b], 0);
        chk("R11", "read strobe latency", r_cyc[b] - rise_cyc[0], 3);
        chk("R10", "miso short cmd byte", int'(rxb[0]), 0);
    endtask

    task automatic t_long_write();
        int b = nw;
        logic [15:0] c = lcmd('h2C5, 1'b1);
        txb[0] = c[15:8]; txb[1] = c[7:0]; txb[2] = 8'h3C;
        spi_run(24);
        chk("R4", "long write count", nw - b, 1);
        chk("R4", "long write addr", w_addr[b], 'h2C5);
        chk("R4", "long write space", w_long[b], 1);
        chk("R4", "long write data", w_data[b], 'h3C);
        chk("R11", "long write latency", w_cyc[b] - rise_cyc[2], 3);
    endtask

    task automatic t_long_read(input int a, input int exp);
        int b = nr;
        logic [15:0] c = lcmd(a, 1'b0);
        txb[0] = c[15:8]; txb[1] = c[7:0]; txb[2] = 8'h00;
        spi_run(24);
        chk("R5", "long read data", int'(rxb[2]), exp);
        chk("R5", "long read addr", r_addr[b], a);
        chk("R5", "long read space", r_long[b], 1);
        chk("R10", "miso long cmd bytes", int'({rxb[0], rxb[1]}), 0);
    endtask

    task automatic t_burst_long();
        int b = nw;
        logic [15:0] c = lcmd('h3FE, 1'b1);
        int exp_a [4] = '{'h3FE, 'h3FF, 'h000, 'h001};
        int exp_d [4] = '{'h11, 'h22, 'h33, 'h44};
        txb[0] = c[15:8]; txb[1] = c[7:0];
        for (int i = 0; i < 4; i++) txb[2 + i] = 8'(exp_d[i]);
        spi_run(48);
        chk("R6", "long burst write count", nw - b, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R6", "long burst write addr", w_addr[b + i], exp_a[i]);
            chk("R6", "long burst write data", w_data[b + i], exp_d[i]);
        end
        b = nr;
        c = lcmd('h3FE, 1'b0);
        txb[0] = c[15:8]; txb[1] = c[7:0];
        for (int i = 0; i < 4; i++) txb[2 + i] = 8'h00;
        spi_run(48);
        for (int i = 0; i < 4; i++) begin
            chk("R7", "long burst read data", int'(rxb[2 + i]), exp_d[i]);
            chk("R7", "long burst read addr", r_addr[b + i], exp_a[i]);
        end
    endtask

    task automatic t_burst_short();
        int b = nw;
        txb[0] = scmd(6'h3F, 1'b1); txb[1] = 8'h5A; txb[2] = 8'hC3;
        spi_run(24);
        chk("R6", "short burst count", nw - b, 2);
        chk("R6", "short burst addr 0", w_addr[b], 'h3F);
        chk("R6", "short burst wrap addr", w_addr[b + 1], 'h00);
        chk("R6", "short burst wrap space", w_long[b + 1], 0);
        chk("R6", "short burst data 1", w_data[b + 1], 'hC3);
        b = nr;
        txb[0] = scmd(6'h3F, 1'b0); txb[1] = 8'h00; txb[2] = 8'h00;
        spi_run(24);
        chk("R7", "short burst read 0", int'(rxb[1]), 'h5A);
        chk("R7", "short burst read 1", int'(rxb[2]), 'hC3);
        chk("R7", "short burst read wrap addr", r_addr[b + 1], 'h00);
    endtask

    task automatic t_abort();
        int bw = nw;
        int br = nr;
        logic [15:0] c;
        txb[0] = scmd(6'h15, 1'b1);
        spi_run(5);
        chk("R8", "no write after partial cmd", nw - bw, 0);
        chk("R8", "no read after partial cmd", nr - br, 0);
        txb[0] = scmd(6'h02, 1'b1); txb[1] = 8'h99;
        spi_run(16);
        chk("R8", "fresh decode write count", nw - bw, 1);
        chk("R8", "fresh decode addr", w_addr[bw], 'h02);
        chk("R8", "fresh decode data", w_data[bw], 'h99);
        bw = nw; br = nr;
        c = lcmd('h155, 1'b1);
        txb[0] = c[15:8]; txb[1] = c[7:0];
        spi_run(12);
        chk("R8", "no strobe after partial long cmd", (nw - bw) + (nr - br), 0);
        txb[0] = scmd(6'h21, 1'b1); txb[1] = 8'h66;
        spi_run(12);
        chk("R8", "partial data byte not written", nw - bw, 0);
        chk("R8", "partial data byte keeps register", int'(smem[6'h21]), int'(init_s('h21)));
        txb[0] = scmd(6'h02, 1'b0); txb[1] = 8'h00;
        spi_run(16);
        chk("R8", "short read after aborts", int'(rxb[1]), 'h99);
    endtask

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);
        t_reset();
        t_short_write();
        t_short_read();
        t_long_write();
        t_long_read('h2C5, 'h3C);
        t_long_read('h301, int'(init_l('h301)));
        t_burst_long();
        t_burst_short();
        t_abort();
        chk("R9", "strobes overlapping", overlap, 0);
        summary();
        $finish;
    end

endmodule